// File: doc/BRIEF.md
# Bit Scan and Zero-Count Unit

This unit takes one 32- or 64-bit source operand and produces one of four related answers: the position of the lowest set bit, the position of the highest set bit, the number of zeros below the lowest set bit, or the number of zeros above the highest set bit. Along with the answer it raises a carry flag and a zero flag. A direction select picks the low or the high end of the operand. A count select picks the counting behaviour over the older position-scan behaviour. When the feature-enable input is low, the unit behaves like an older core: it ignores the count select and always applies scan behaviour.

Both behaviours share one pair of priority encoders. The low end is found directly. The high end is found on a bit-reversed copy of the operand. A small selector then applies the flag rules and the zero-source corner cases of each behaviour. With a zero source, scan behaviour defines no result, so the unit passes a caller-supplied prior destination value through unchanged, which makes that case deterministic. The result and flags are registered and appear one cycle after `in_valid`, together with `out_valid`.

Top module: `bitscan_unit`

## Requirements
- R1: With `in_dir_high`=0 and a nonzero examined source, count behaviour returns the index of the lowest set bit, and scan behaviour returns the same value.
- R2: With `in_dir_high`=1 and a nonzero examined source, scan behaviour returns the index of the highest set bit, and count behaviour returns (operand width − 1 − that index).
- R3: In count behaviour with a zero examined source, the result equals the operand width (32 when `in_wide`=0, 64 when `in_wide`=1), `out_cf`=1 and `out_zf`=0.
- R4: In count behaviour with a nonzero examined source, `out_cf`=0, and `out_zf`=1 exactly when the count is 0 (for example, an all-ones source).
- R5: In scan behaviour with a zero examined source, `out_result` equals `in_prior` unchanged, `out_zf`=1 and `out_cf`=0.
- R6: In scan behaviour with a nonzero examined source, `out_zf`=0 and `out_cf`=0.
- R7: Count behaviour applies only when `in_count_sel`=1 and `feat_en`=1. With `feat_en`=0 the count select is ignored and scan behaviour applies.
- R8: With `in_wide`=0, only bits 31:0 of `in_src` are examined, and every nonpass-through result is zero-extended to 64 bits.
- R9: The result and flags for a request taken with `in_valid`=1 appear one clock later with `out_valid`=1. In a cycle after `in_valid`=0, `out_valid` is 0 and the result and flags hold their previous values.
- R10: While `rst_n` is low and after it is released, before any request, `out_valid`, `out_result`, `out_cf` and `out_zf` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_src | input | 64 | Source operand |
| in_wide | input | 1 | 1 = 64-bit operand, 0 = 32-bit operand |
| in_dir_high | input | 1 | 0 = low end (lowest bit / trailing zeros), 1 = high end (highest bit / leading zeros) |
| in_count_sel | input | 1 | 1 = request count behaviour (the prefixed form) |
| feat_en | input | 1 | 1 = count behaviour supported |
| in_prior | input | 64 | Prior destination value, returned when a scan sees a zero source |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_result | output | 64 | Index or count, or `in_prior` on a zero-source scan |
| out_cf | output | 1 | Carry flag |
| out_zf | output | 1 | Zero flag |

## Verification
The assertions check on every cycle the one-cycle pairing of `in_valid` and `out_valid`, the flag patterns and result values of both zero-source corner cases, the flags of nonzero scans, and the rule that carry and zero flags are never raised together. Only the bench scenarios show the numeric indices and counts: the single-bit walks in both operand sizes, the all-ones cases, the upper-half masking of narrow operands, and the fallback when the feature is off. Those scenarios compare against a bit-by-bit loop model.

// File: rtl/bitscan_pkg.sv
package bitscan_pkg;

    localparam int BS_XLEN = 64;

    typedef enum logic [1:0] {
        OP_SCAN_LOW  = 2'd0,
        OP_SCAN_HIGH = 2'd1,
        OP_CNT_TRAIL = 2'd2,
        OP_CNT_LEAD  = 2'd3
    } bs_op_e;

endpackage

// File: rtl/bitscan_op_decode.sv
module bitscan_op_decode
    import bitscan_pkg::*;
(
    input  logic   dir_high,
    input  logic   count_sel,
    input  logic   feat_en,
    output bs_op_e op
);
    logic count_eff;

    // Without the feature the prefix is ignored: fall back to scanning.
    assign count_eff = count_sel & feat_en;

    always_comb begin
        unique case ({count_eff, dir_high})
            2'b00:   op = OP_SCAN_LOW;
            2'b01:   op = OP_SCAN_HIGH;
            2'b10:   op = OP_CNT_TRAIL;
            default: op = OP_CNT_LEAD;
        endcase
    end
endmodule

// File: rtl/bitscan_lsb_find.sv
module bitscan_lsb_find #(
    parameter int W    = 64,
    parameter int IDXW = $clog2(W + 1)
) (
    input  logic [W-1:0]    vec,
    output logic [IDXW-1:0] idx,
    output logic            found
);
    always_comb begin
        idx   = '0;
        found = |vec;
        // Walk downward so the lowest set bit is the last one written.
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IDXW'(i);
            end
        end
    end
endmodule

// File: rtl/bitscan_result_sel.sv
module bitscan_result_sel
    import bitscan_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int IDXW = $clog2(XLEN + 1)
) (
    input  bs_op_e            op,
    input  logic              wide,
    input  logic              nonzero,
    input  logic [IDXW-1:0]   lo_idx,
    input  logic [IDXW-1:0]   hi_idx,
    input  logic [XLEN-1:0]   prior,
    output logic [XLEN-1:0]   result,
    output logic              cf,
    output logic              zf
);
    localparam int HALF = XLEN / 2;
    localparam int PADW = XLEN - IDXW;

    logic [IDXW-1:0] width_val;
    logic [IDXW-1:0] top_bit;
    logic [IDXW-1:0] count_val;

    assign width_val = wide ? IDXW'(XLEN) : IDXW'(HALF);
    assign top_bit   = width_val - IDXW'(1);

    always_comb begin
        result    = '0;
        cf        = 1'b0;
        zf        = 1'b0;
        count_val = '0;
        unique case (op)
            OP_SCAN_LOW, OP_SCAN_HIGH: begin
                if (nonzero) begin
                    result = {{PADW{1'b0}}, (op == OP_SCAN_LOW) ? lo_idx : hi_idx};
                    zf     = 1'b0;
                end else begin
                    result = prior;
                    zf     = 1'b1;
                end
                cf = 1'b0;
            end
            default: begin
                if (!nonzero) begin
                    count_val = width_val;
                end else if (op == OP_CNT_TRAIL) begin
                    count_val = lo_idx;
                end else begin
                    count_val = top_bit - hi_idx;
                end
                result = {{PADW{1'b0}}, count_val};
                cf     = ~nonzero;
                zf     = (count_val == '0);
            end
        endcase
    end
endmodule

// File: rtl/bitscan_unit.sv
module bitscan_unit
    import bitscan_pkg::*;
#(
    parameter int XLEN    = BS_XLEN,
    parameter bit OUT_REG = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [XLEN-1:0] in_src,
    input  logic            in_wide,
    input  logic            in_dir_high,
    input  logic            in_count_sel,
    input  logic            feat_en,
    input  logic [XLEN-1:0] in_prior,
    output logic            out_valid,
    output logic [XLEN-1:0] out_result,
    output logic            out_cf,
    output logic            out_zf
);
    localparam int HALF = XLEN / 2;
    localparam int IDXW = $clog2(XLEN + 1);

    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] result;
        logic            cf;
        logic            zf;
    } out_s;

    logic [XLEN-1:0] src_m;
    logic [XLEN-1:0] src_rev;
    logic [IDXW-1:0] lo_idx;
    logic [IDXW-1:0] rev_idx;
    logic [IDXW-1:0] hi_idx;
    logic            lo_found;
    logic            rev_found;
    bs_op_e          op;
    logic [XLEN-1:0] sel_result;
    logic            sel_cf;
    logic            sel_zf;
    out_s            out_d;
    out_s            out_q;

    // Narrow operands examine only the low half.
    assign src_m = in_wide ? in_src : {{HALF{1'b0}}, in_src[HALF-1:0]};

    // The high end is found as the lowest set bit of the reversed operand.
    for (genvar g = 0; g < XLEN; g++) begin : g_rev
        assign src_rev[g] = src_m[XLEN-1-g];
    end

    bitscan_lsb_find #(.W(XLEN), .IDXW(IDXW)) u_lo_find (
        .vec   (src_m),
        .idx   (lo_idx),
        .found (lo_found)
    );

    bitscan_lsb_find #(.W(XLEN), .IDXW(IDXW)) u_hi_find (
        .vec   (src_rev),
        .idx   (rev_idx),
        .found (rev_found)
    );

    assign hi_idx = IDXW'(XLEN - 1) - rev_idx;

    bitscan_op_decode u_dec (
        .dir_high  (in_dir_high),
        .count_sel (in_count_sel),
        .feat_en   (feat_en),
        .op        (op)
    );

    bitscan_result_sel #(.XLEN(XLEN), .IDXW(IDXW)) u_sel (
        .op      (op),
        .wide    (in_wide),
        .nonzero (lo_found & rev_found),
        .lo_idx  (lo_idx),
        .hi_idx  (hi_idx),
        .prior   (in_prior),
        .result  (sel_result),
        .cf      (sel_cf),
        .zf      (sel_zf)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = in_valid;
        if (in_valid) begin
            out_d.result = sel_result;
            out_d.cf     = sel_cf;
            out_d.zf     = sel_zf;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    if (OUT_REG) begin : g_reg_out
        assign out_valid  = out_q.valid;
        assign out_result = out_q.result;
        assign out_cf     = out_q.cf;
        assign out_zf     = out_q.zf;
    end else begin : g_comb_out
        assign out_valid  = out_d.valid;
        assign out_result = out_d.result;
        assign out_cf     = out_d.cf;
        assign out_zf     = out_d.zf;
    end
endmodule

// File: rtl/bitscan_unit_chk.sv
module bitscan_unit_chk #(
    parameter int XLEN    = 64,
    parameter bit OUT_REG = 1'b1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [XLEN-1:0] in_src,
    input logic            in_wide,
    input logic            in_count_sel,
    input logic            feat_en,
    input logic [XLEN-1:0] in_prior,
    input logic            out_valid,
    input logic [XLEN-1:0] out_result,
    input logic            out_cf,
    input logic            out_zf
);
    localparam int HALF = XLEN / 2;

    logic            src_zero;
    logic            cnt_mode;
    logic [XLEN-1:0] exp_width;

    assign src_zero  = in_wide ? (in_src == '0) : (in_src[HALF-1:0] == '0);
    assign cnt_mode  = in_count_sel & feat_en;
    assign exp_width = in_wide ? XLEN'(XLEN) : XLEN'(HALF);

    // R9
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n || !OUT_REG)
        in_valid |=> out_valid);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n || !OUT_REG)
        !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_cf) && $stable(out_zf)));

    // R3
    count_zero_chk: assert property (@(posedge clk) disable iff (!rst_n || !OUT_REG)
        (in_valid && cnt_mode && src_zero) |=>
            (out_cf && !out_zf && out_result == $past(exp_width)));

    // R5
    scan_zero_chk: assert property (@(posedge clk) disable iff (!rst_n || !OUT_REG)
        (in_valid && !cnt_mode && src_zero) |=>
            (out_zf && !out_cf && out_result == $past(in_prior)));

    // R6
    scan_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n || !OUT_REG)
        (in_valid && !cnt_mode && !src_zero) |=> (!out_zf && !out_cf));

    // R4
    count_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n || !OUT_REG)
        (in_valid && cnt_mode && !src_zero) |=>
            (!out_cf && (out_zf == (out_result == '0))));

    // R4
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_cf && out_zf));
endmodule

bind bitscan_unit bitscan_unit_chk #(.XLEN(XLEN), .OUT_REG(OUT_REG)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_src       (in_src),
    .in_wide      (in_wide),
    .in_count_sel (in_count_sel),
    .feat_en      (feat_en),
    .in_prior     (in_prior),
    .out_valid    (out_valid),
    .out_result   (out_result),
    .out_cf       (out_cf),
    .out_zf       (out_zf)
);

// File: tb/bitscan_unit_tb_top.sv
`timescale 1ns/1ps
module bitscan_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_src = '0;
    logic        in_wide = 1'b0;
    logic        in_dir_high = 1'b0;
    logic        in_count_sel = 1'b0;
    logic        feat_en = 1'b0;
    logic [63:0] in_prior = '0;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_cf;
    logic        out_zf;

    int n_checks = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    bitscan_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_src(in_src),
        .in_wide(in_wide), .in_dir_high(in_dir_high), .in_count_sel(in_count_sel),
        .feat_en(feat_en), .in_prior(in_prior), .out_valid(out_valid),
        .out_result(out_result), .out_cf(out_cf), .out_zf(out_zf)
    );

    task automatic check(input string req, input string what, input logic [65:0] act,
                         input logic [65:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Bit-by-bit model of the requirements.
    task automatic model(input logic [63:0] src, input logic wide, input logic dir,
                         input logic cnt, input logic feat, input logic [63:0] prior,
                         output logic [63:0] r, output logic cf, output logic zf);
        int w = wide ? 64 : 32;
        int lo = -1;
        int hi = -1;
        for (int i = 0; i < w; i++) begin
            if (src[i]) begin
                if (lo < 0) lo = i;
                hi = i;
            end
        end
        if (cnt && feat) begin
            if (lo < 0) r = 64'(w);
            else if (!dir) r = 64'(lo);
            else r = 64'(w - 1 - hi);
            cf = (lo < 0);
            zf = (r == 0);
        end else begin
            if (lo < 0) begin
                r = prior; zf = 1'b1;
            end else begin
                r = dir ? 64'(hi) : 64'(lo); zf = 1'b0;
            end
            cf = 1'b0;
        end
    endtask

    task automatic run_op(input string req, input logic [63:0] src, input logic wide,
                          input logic dir, input logic cnt, input logic feat,
                          input logic [63:0] prior);
        logic [63:0] er;
        logic ecf, ezf;
        model(src, wide, dir, cnt, feat, prior, er, ecf, ezf);
        @(negedge clk);
        in_valid = 1'b1; in_src = src; in_wide = wide; in_dir_high = dir;
        in_count_sel = cnt; feat_en = feat; in_prior = prior;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, $sformatf("src=%h w=%0b d=%0b c=%0b f=%0b", src, wide, dir, cnt, feat),
              {out_valid, out_cf, out_zf, out_result[62:0]},
              {1'b1, ecf, ezf, er[62:0]});
        check(req, "result bit63", {65'b0, out_result[63]}, {65'b0, er[63]});
    endtask

    task automatic t_reset;
        check("R10", "during reset", {out_valid, out_cf, out_zf, out_result[62:0]}, '0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R10", "after release", {out_valid, out_cf, out_zf, out_result[62:0]}, '0);
    endtask

    task automatic t_zero;
        for (int m = 0; m < 8; m++) begin
            run_op(m[3] ? "R5" : "R3", 64'h0, m[0], m[1], 1'b1, 1'b1, 64'hdead_beef_0bad_f00d);
        end
        run_op("R3", 64'h0, 1'b0, 1'b0, 1'b1, 1'b1, '0);
        run_op("R3", 64'h0, 1'b1, 1'b1, 1'b1, 1'b1, '0);
        run_op("R5", 64'h0, 1'b0, 1'b0, 1'b0, 1'b1, 64'h1234_5678_9abc_def0);
        run_op("R5", 64'h0, 1'b1, 1'b1, 1'b0, 1'b0, 64'hffff_0000_ffff_0000);
    endtask

    task automatic t_ones;
        run_op("R4", 64'hffff_ffff, 1'b0, 1'b1, 1'b1, 1'b1, '0);
        run_op("R4", 64'hffff_ffff, 1'b0, 1'b0, 1'b1, 1'b1, '0);
        run_op("R2", 64'hffff_ffff, 1'b0, 1'b1, 1'b0, 1'b1, '0);
        run_op("R6", '1, 1'b1, 1'b0, 1'b0, 1'b1, '0);
        run_op("R4", '1, 1'b1, 1'b1, 1'b1, 1'b1, '0);
        run_op("R1", 64'he000, 1'b1, 1'b0, 1'b1, 1'b1, '0);
        run_op("R1", 64'he000, 1'b1, 1'b0, 1'b0, 1'b1, '0);
    endtask

    task automatic t_single_bits;
        for (int b = 0; b < 64; b++) begin
            run_op("R1", 64'b1 << b, 1'b1, 1'b0, 1'b1, 1'b1, '0);
            run_op("R2", 64'b1 << b, 1'b1, 1'b1, 1'b1, 1'b1, '0);
            run_op("R2", 64'b1 << b, 1'b1, 1'b1, 1'b0, 1'b1, '0);
        end
        for (int b = 0; b < 32; b++) begin
            run_op("R2", 64'b1 << b, 1'b0, 1'b1, 1'b1, 1'b1, '0);
            run_op("R1", (64'b1 << b) | 64'h8000_0000, 1'b0, 1'b0, 1'b1, 1'b1, '0);
        end
    endtask

    task automatic t_narrow_upper;
        run_op("R8", 64'hffff_ffff_0000_0000, 1'b0, 1'b0, 1'b1, 1'b1, '0);
        run_op("R8", 64'h8000_0000_0000_0010, 1'b0, 1'b1, 1'b1, 1'b1, '0);
        run_op("R8", 64'h8000_0000_0000_0010, 1'b0, 1'b1, 1'b0, 1'b1, '0);
        run_op("R8", 64'habcd_0000_0000_0000, 1'b0, 1'b1, 1'b0, 1'b1, 64'h5555_aaaa_5555_aaaa);
    endtask

    task automatic t_feature_off;
        run_op("R7", 64'h0, 1'b0, 1'b0, 1'b1, 1'b0, 64'h0000_0000_cafe_babe);
        run_op("R7", 64'h0000_0100, 1'b0, 1'b1, 1'b1, 1'b0, '0);
        run_op("R7", '1, 1'b1, 1'b1, 1'b1, 1'b0, '0);
        run_op("R7", 64'h0080_0000_0000_0000, 1'b1, 1'b0, 1'b1, 1'b0, '0);
    endtask

    task automatic t_hold;
        logic [63:0] held_r;
        logic held_cf, held_zf;
        run_op("R9", 64'h0000_0040_0000_0000, 1'b1, 1'b1, 1'b1, 1'b1, '0);
        held_r = out_result; held_cf = out_cf; held_zf = out_zf;
        in_src = '1; in_dir_high = 1'b0; in_prior = '1;
        @(negedge clk);
        check("R9", "idle valid low", {65'b0, out_valid}, '0);
        check("R9", "idle hold", {out_cf, out_zf, out_result}, {held_cf, held_zf, held_r});
    endtask

    task automatic t_random;
        for (int k = 0; k < 300; k++) begin
            logic [63:0] s;
            logic [63:0] p;
            logic [4:0] ctl;
            s = {$urandom, $urandom};
            p = {$urandom, $urandom};
            ctl = 5'($urandom);
            if (ctl[4]) s = s & (s << ($urandom % 40)) & ({$urandom, $urandom});
            if (ctl[3] && ctl[2]) s = '0;
            run_op(ctl[2] ? "R1" : "R2", s, ctl[0], ctl[1], ctl[2], ctl[3] | ctl[4], p);
        end
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(5.0 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_zero();
        t_ones();
        t_single_bits();
        t_narrow_upper();
        t_feature_off();
        t_hold();
        t_random();
        report();
    end
endmodule